// File: doc/BRIEF.md
# Round-Robin Event Assignment Manager

This block is the central dispatcher of a push-style data gathering fabric with N sources and N destinations. Each destination signals that it can take one more event by pulsing its bit on a request vector. The block keeps a count of open requests for each destination. It hands each new event number to one requesting destination, choosing them in rotation. The result is one stream of (event id, destination) pairs that goes to every source. A source then sends its fragment of that event to the destination named in the pair.

The pairs leave on a valid/ready stream and are framed into batches. Each batch carries a start flag on its first entry and an end flag on its last entry. A batch always holds a whole number of rounds of N entries and never more than 352. The batch size comes from a configuration input, which is read when the first entry of each batch is made. An illegal value is replaced by N. When the stream is held back, assignment stops, so no event number is consumed early.

Top module: `erq_assigner`

## Requirements
- R1: After a synchronous reset, `out_valid` is low, every request count is zero, the first event id issued is 0, and the first search for a destination starts at destination 0.
- R2: Only destinations with an open request receive events. Each request accepted on `req_vec[d]` yields exactly one assignment to destination d.
- R3: The search for the next destination starts at the index after the most recently granted destination and moves up through the indices, wrapping from N-1 to 0. The first destination found with an open request is granted.
- R4: Event ids are issued in order, starting at 0 and rising by exactly one per assignment, with no gaps.
- R5: `out_sob` is set on the first entry of a batch and `out_eob` on its last. A batch holds exactly the size read from `batch_size` when its first entry was made.
- R6: A `batch_size` value is legal when it is non-zero, a multiple of N and at most 352. An illegal value gives batches of N entries.
- R7: While `out_valid` is high and `out_ready` is low, the presented entry stays stable and no further event is assigned.
- R8: Each destination's request count saturates at 2^CNT_W-1. A request that arrives at a full count, with no grant to that destination in the same cycle, is dropped.
- R9: With the block idle and its output empty, a request pulse in cycle t makes `out_valid` rise after the second rising clock edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vec | input | N_DEST | One bit per destination; a high bit adds one open request |
| batch_size | input | CFG_W | Requested entries per batch, read at the start of each batch |
| out_ready | input | 1 | Downstream accepts the presented entry |
| out_valid | output | 1 | An assignment entry is presented |
| out_evtid | output | ID_W | Event number of the entry |
| out_dest | output | $clog2(N_DEST) | Destination granted this event |
| out_sob | output | 1 | Entry opens a batch |
| out_eob | output | 1 | Entry closes a batch |

## Verification
A request is counted at the first clock edge. The grant is registered into the output stage at the second edge, so from an idle state the entry is visible two edges after the request. The bench checks this exact cycle at falling edges. Stall and rotation order are checked as follows: the driver only posts requests when the design holds no older open requests, or while the output stage is stalled. Within each step of a burst it applies exactly one model grant. With this discipline the expected entries in the scoreboard queue come out in the same order as the design's grants, whatever pattern of back-pressure the monitor sees. Each accepted entry is then compared on destination, event id and batch flags when its handshake falls.

// File: rtl/erq_pkg.sv
package erq_pkg;

    localparam int unsigned BATCH_CAP = 352;

    // A batch length is usable when it is non-zero, covers whole rounds and fits the cap
    function automatic logic size_ok(int unsigned sz, int unsigned n, int unsigned cap);
        return (sz != 0) && ((sz % n) == 0) && (sz <= cap);
    endfunction

endpackage

// File: rtl/erq_req_bank.sv
module erq_req_bank #(
    parameter int N_DEST = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_DEST-1:0] req_vec,
    input  logic [N_DEST-1:0] dec_vec,
    output logic [N_DEST-1:0] pending
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar g = 0; g < N_DEST; g++) begin : g_lane
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (req_vec[g] && !dec_vec[g] && cnt_q != CNT_MAX)
                cnt_d = cnt_q + 1'b1;
            else if (dec_vec[g] && !req_vec[g])
                cnt_d = cnt_q - 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_d;
        end

        assign pending[g] = (cnt_q != '0);
    end

    // R2: at most one destination is charged per cycle
    p_one_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec_vec));

    // R2: a grant never lands on a destination without an open request
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_vec & ~pending) == '0);

endmodule

// File: rtl/erq_rr_pick.sv
module erq_rr_pick #(
    parameter int N_DEST = 8,
    localparam int DW = $clog2(N_DEST)
) (
    input  logic [N_DEST-1:0] mask,
    input  logic [DW-1:0]     ptr,
    output logic              found,
    output logic [DW-1:0]     idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        // walk offsets from far to near so the nearest set bit wins
        for (int k = N_DEST - 1; k >= 0; k--) begin
            int j;
            j = (int'(ptr) + k) % N_DEST;
            if (mask[j]) begin
                found = 1'b1;
                idx   = DW'(j);
            end
        end
    end
endmodule

// File: rtl/erq_assigner.sv
module erq_assigner #(
    parameter int N_DEST    = 8,
    parameter int CNT_W     = 4,
    parameter int ID_W      = 32,
    parameter int CFG_W     = 10,
    parameter int MAX_BATCH = erq_pkg::BATCH_CAP,
    localparam int DW = $clog2(N_DEST)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_DEST-1:0] req_vec,
    input  logic [CFG_W-1:0]  batch_size,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ID_W-1:0]   out_evtid,
    output logic [DW-1:0]     out_dest,
    output logic              out_sob,
    output logic              out_eob
);
    typedef struct packed {
        logic             vld;
        logic [ID_W-1:0]  evt_out;
        logic [DW-1:0]    dest;
        logic             sob;
        logic             eob;
        logic [ID_W-1:0]  evt;
        logic [DW-1:0]    ptr;
        logic [CFG_W-1:0] pos;
        logic [CFG_W-1:0] size;
    } st_t;

    st_t st_d, st_q;

    logic [N_DEST-1:0] pending;
    logic [N_DEST-1:0] dec_vec;
    logic              found;
    logic [DW-1:0]     pick;
    logic              load, grant;
    logic              cfg_ok;
    logic [CFG_W-1:0]  cur_size;

    erq_req_bank #(.N_DEST(N_DEST), .CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req_vec (req_vec),
        .dec_vec (dec_vec),
        .pending (pending)
    );

    erq_rr_pick #(.N_DEST(N_DEST)) u_pick (
        .mask  (pending),
        .ptr   (st_q.ptr),
        .found (found),
        .idx   (pick)
    );

    always_comb begin
        st_d     = st_q;
        load     = !st_q.vld || out_ready;
        grant    = load && found;
        cfg_ok   = erq_pkg::size_ok(int'(batch_size), N_DEST, MAX_BATCH);
        cur_size = (st_q.pos == '0) ? (cfg_ok ? batch_size : CFG_W'(N_DEST)) : st_q.size;
        dec_vec  = '0;

        if (load) st_d.vld = found;
        if (grant) begin
            dec_vec[pick] = 1'b1;
            st_d.evt_out  = st_q.evt;
            st_d.dest     = pick;
            st_d.sob      = (st_q.pos == '0);
            st_d.eob      = (st_q.pos + 1'b1 == cur_size);
            st_d.evt      = st_q.evt + 1'b1;
            st_d.ptr      = (pick == DW'(N_DEST - 1)) ? '0 : pick + 1'b1;
            st_d.pos      = st_d.eob ? '0 : st_q.pos + 1'b1;
            st_d.size     = cur_size;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.size <= CFG_W'(N_DEST);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_evtid = st_q.evt_out;
    assign out_dest  = st_q.dest;
    assign out_sob   = st_q.sob;
    assign out_eob   = st_q.eob;

    // R1: the first cycle out of reset presents nothing
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R4: the entry following an accepted one carries the next event number
    p_evt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid || out_evtid == $past(out_evtid) + 1'b1));

    // R5: position within a batch stays below the latched batch length
    p_pos_bound_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.pos < st_q.size);

    // R6: the latched batch length is always a legal one
    p_size_legal_r6: assert property (@(posedge clk) disable iff (rst)
        erq_pkg::size_ok(int'(st_q.size), N_DEST, MAX_BATCH));

    // R7: a stalled entry is held unchanged
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_evtid) && $stable(out_dest)
                                       && $stable(out_sob) && $stable(out_eob)));

endmodule

// File: tb/tb_erq_assigner.sv
module tb_erq_assigner;
    localparam int N    = 8;
    localparam int CMAX = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req_vec = '0;
    logic [9:0]    batch_size = 10'd8;
    logic          out_ready;
    logic          out_valid;
    logic [31:0]   out_evtid;
    logic [2:0]    out_dest;
    logic          out_sob, out_eob;

    logic          ready_hold = 1'b1;
    logic          stall_mode = 1'b0;
    logic          pat_q = 1'b1;
    logic [7:0]    lfsr = 8'h5a;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign out_ready = ready_hold && (!stall_mode || pat_q);

    always @(posedge clk) begin
        #1;
        lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        pat_q = lfsr[0] | lfsr[3];
    end

    erq_assigner dut (
        .clk(clk), .rst(rst), .req_vec(req_vec), .batch_size(batch_size),
        .out_ready(out_ready), .out_valid(out_valid), .out_evtid(out_evtid),
        .out_dest(out_dest), .out_sob(out_sob), .out_eob(out_eob)
    );

    // ---------------- reference model ----------------
    typedef struct { int unsigned evt; int dest; bit sob; bit eob; } exp_t;
    exp_t q[$];
    int mcnt[N];
    int mptr = 0;
    int unsigned mevt = 0;
    int mpos = 0;
    int msize = N;

    function automatic int legal_size(int sz);
        if (sz != 0 && sz % N == 0 && sz <= 352) return sz;
        return N;
    endfunction

    function automatic void madd(logic [N-1:0] v);
        for (int d = 0; d < N; d++)
            if (v[d] && mcnt[d] < CMAX) mcnt[d]++;
    endfunction

    function automatic bit mgrant();
        exp_t e;
        int cur;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (mptr + k) % N;
            if (mcnt[j] > 0) begin
                cur = (mpos == 0) ? legal_size(int'(batch_size)) : msize;
                if (mpos == 0) msize = cur;
                e.evt = mevt; e.dest = j; e.sob = (mpos == 0); e.eob = (mpos + 1 == cur);
                q.push_back(e);
                mcnt[j]--;
                mevt++;
                mptr = (j + 1) % N;
                mpos = e.eob ? 0 : mpos + 1;
                return 1;
            end
        end
        return 0;
    endfunction

    function automatic void mdrain();
        while (mgrant()) ;
    endfunction

    // ---------------- checking ----------------
    task automatic check(bit ok, string tag, longint act, longint exp_v);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    bit          hold_pend = 0;
    logic [31:0] h_evt;
    logic [2:0]  h_dest;
    logic        h_sob, h_eob;

    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend) begin
                // R7: stalled entry must be unchanged
                check(out_valid && out_evtid == h_evt && out_dest == h_dest
                      && out_sob == h_sob && out_eob == h_eob,
                      "R7 stalled entry held (evtid)", out_evtid, h_evt);
            end
            hold_pend = out_valid && !out_ready;
            h_evt = out_evtid; h_dest = out_dest; h_sob = out_sob; h_eob = out_eob;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(0, "R2 unexpected assignment dest", out_dest, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_dest == e.dest[2:0], "R3 destination", out_dest, e.dest);
                    check(out_evtid == e.evt, "R4 event id", out_evtid, e.evt);
                    check({out_sob, out_eob} == {e.sob, e.eob}, "R5 sob/eob flags",
                          {out_sob, out_eob}, {e.sob, e.eob});
                end
            end
        end
    end

    // ---------------- driver tasks (enter/leave at posedge + 1) ----------------
    task automatic pulse(logic [N-1:0] v);
        req_vec = v;
        @(posedge clk); #1;
        req_vec = '0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0 || out_valid);
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic post_idle(logic [N-1:0] v);
        madd(v);
        mdrain();
        pulse(v);
        wait_idle();
    endtask

    // burst of n pulses with the output stalled; one grant fits after the first
    task automatic burst(logic [N-1:0] v, int n);
        ready_hold = 1'b0;
        madd(v);
        pulse(v);
        void'(mgrant());
        for (int i = 1; i < n; i++) begin
            madd(v);
            pulse(v);
        end
        repeat (3) @(posedge clk);
        #1;
        mdrain();
        ready_hold = 1'b1;
        wait_idle();
    endtask

    initial begin
        for (int d = 0; d < N; d++) mcnt[d] = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        @(posedge clk); #1;

        // R1/R3/R4: all destinations, search starts at 0
        post_idle(8'hFF);
        // R3: sparse set from the current pointer
        post_idle(8'b0110_0100);
        post_idle(8'b1000_0001);

        // R9: request-to-output latency from idle
        madd(8'b0000_1000); mdrain();
        req_vec = 8'b0000_1000;
        @(posedge clk); #1 req_vec = '0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 valid one edge after request", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 valid two edges after request", out_valid, 1);
        wait_idle();

        // R2/R3: repeated requests while stalled
        burst(8'b0000_1001, 3);
        // R8: saturation at 15 open requests, 17 posted -> 16 outputs
        burst(8'b0000_1000, 17);

        // R7: random back-pressure
        stall_mode = 1'b1;
        post_idle(8'hFF);
        post_idle(8'b1010_0110);
        burst(8'b0101_0001, 4);
        stall_mode = 1'b0;

        // R5: legal 16-entry batches
        batch_size = 10'd16;
        post_idle(8'hFF);
        post_idle(8'hFF);
        post_idle(8'hFF);
        // R6: illegal sizes fall back to N
        batch_size = 10'd12;
        post_idle(8'hFF);
        post_idle(8'hFF);
        batch_size = 10'd0;
        post_idle(8'hFF);
        // R5/R6: cap of 352 is legal
        batch_size = 10'd352;
        for (int i = 0; i < 45; i++) post_idle(8'hFF);
        // R6: above the cap
        batch_size = 10'd360;
        post_idle(8'hFF);
        post_idle(8'hFF);

        repeat (4) @(posedge clk);
        check(q.size() == 0, "R2 all expected assignments seen", q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", q.size(), 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule